// File: doc/BRIEF.md
# Two-Wire Target with a 16-bit Register Bank

This block is the target side of a two-wire serial bus (I2C-compatible) placed in front of a small bank of 16-bit registers. It samples the raw clock and data lines on the system clock through synchronizers. It finds bus START, repeated START and STOP conditions from the synchronized edges, and it answers a fixed 7-bit address. Its only drive onto the bus is an open-drain pull-down enable for the data line.

A write transfer carries a pointer byte first. The pointer picks one of the registers. Data bytes follow, high byte first. A read transfer returns the register chosen by the most recent pointer, high byte first, and goes on until the controller answers a byte with a not-acknowledge. The register contents are also presented in parallel to the logic that uses them.

Top module: `i2c_wreg_target`

## Requirements
- R1: A START (data falls while clock is high) in any state begins a new address phase. A repeated START with no STOP before it is accepted in the same way.
- R2: A STOP (data rises while clock is high) returns the block to idle with the data line released.
- R3: When the address byte's upper seven bits equal parameter `DEV_ADDR`, the target pulls data low for the whole high time of the ninth clock pulse. Bit 0 of the address byte selects the direction: 0 is write and 1 is read.
- R4: When the address does not match, no acknowledge is given. The target then drives nothing and changes no register until the next START.
- R5: In a write, the first byte after the address is the pointer, and its low two bits select one of four registers. The pointer byte is acknowledged.
- R6: The two data bytes that follow the pointer are stored into the selected register, high byte first, and each one is acknowledged.
- R7: When a write ends (STOP or repeated START) after only one data byte, that byte is stored as the high byte and the low byte keeps its value.
- R8: Data bytes past the second keep alternating high, low, high, and so on into the same register.
- R9: A read returns the register selected by the last stored pointer, high byte first, with each bit driven while the clock is low.
- R10: A read of more than two bytes goes back to the high byte of the same register.
- R11: After the controller leaves data high on the acknowledge slot of a read, the target releases data and drives nothing more until the next START.
- R12: The data output enable changes only while the synchronized clock is low, so data is stable through every clock high period.
- R13: Reset clears all registers and the pointer to zero and releases data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| regs_o | output | 64 | All registers, register k in bits 16k+15..16k |

## Verification
A wrong bit count or a wrong state appears at the ports within one byte time. It shows either as a missing acknowledge or as an acknowledge in the wrong slot, seen on the ninth pulse, or as read data shifted by one bit. A wrong pointer or a wrong byte-half toggle shows up in the parallel register output a few system clocks after the acknowledge of the byte concerned, or in the next read. A target that fails to let go after a not-acknowledge or a mismatch is seen as the line held low on the next controller-driven clock pulse.

// File: rtl/i2c_wreg_pkg.sv
package i2c_wreg_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int BITCNT_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_PTR,
        ST_PACK,
        ST_WDAT,
        ST_WACK,
        ST_TX,
        ST_RACK,
        ST_SKIP
    } bus_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w, input logic hi);
        return hi ? w[WORD_W-1 -: BYTE_W] : w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/i2c_wreg_cond.sv
module i2c_wreg_cond
    import i2c_wreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_ff[STAGES-1];
            sda_d <= sda_ff[STAGES-1];
        end
    end

    always_comb begin
        evt.scl      = scl_ff[STAGES-1];
        evt.sda      = sda_ff[STAGES-1];
        evt.scl_rise = evt.scl & ~scl_d;
        evt.scl_fall = ~evt.scl & scl_d;
        evt.start    = evt.scl & scl_d & sda_d & ~evt.sda;
        evt.stop     = evt.scl & scl_d & ~sda_d & evt.sda;
    end

endmodule

// File: rtl/i2c_wreg_bank.sv
module i2c_wreg_bank
    import i2c_wreg_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int PTR_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we_hi,
    input  logic                   we_lo,
    input  logic [PTR_W-1:0]       widx,
    input  logic [BYTE_W-1:0]      wbyte,
    input  logic [PTR_W-1:0]       ridx,
    output logic [WORD_W-1:0]      rword,
    output logic [NREG*WORD_W-1:0] flat
);

    logic [WORD_W-1:0] q [NREG];

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    q[i] <= '0;
                end else if (widx == PTR_W'(i)) begin
                    if (we_hi) q[i][WORD_W-1 -: BYTE_W] <= wbyte;
                    if (we_lo) q[i][BYTE_W-1:0]         <= wbyte;
                end
            end
            assign flat[i*WORD_W +: WORD_W] = q[i];

            a_r6_hi_store: assert property (@(posedge clk) disable iff (rst)
                (we_hi && widx == PTR_W'(i)) |=> q[i][WORD_W-1 -: BYTE_W] == $past(wbyte));
            a_r7_lo_kept: assert property (@(posedge clk) disable iff (rst)
                (!we_lo) |=> q[i][BYTE_W-1:0] == $past(q[i][BYTE_W-1:0]));
        end
    endgenerate

    assign rword = q[ridx];

endmodule

// File: rtl/i2c_wreg_target.sv
module i2c_wreg_target
    import i2c_wreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C,
    parameter int         NREG     = 4,
    parameter int         STAGES   = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [NREG*WORD_W-1:0] regs_o
);

    localparam int PTR_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(BYTE_W);

    bus_evt_t           evt;
    bus_state_t         state;
    logic [BITCNT_W-1:0] cnt;
    logic [BYTE_W-1:0]  rx_sh;
    logic [BYTE_W-1:0]  tx_sh;
    logic               oe_q;
    logic [PTR_W-1:0]   ptr_q;
    logic               wr_hi_q;
    logic               rd_hi_q;
    logic               nack_q;
    logic [WORD_W-1:0]  rword;
    logic               byte_done;
    logic               we_hi;
    logic               we_lo;
    logic [BYTE_W-1:0]  next_tx;

    i2c_wreg_cond #(.STAGES(STAGES)) u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_wreg_bank #(.NREG(NREG), .PTR_W(PTR_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we_hi (we_hi),
        .we_lo (we_lo),
        .widx  (ptr_q),
        .wbyte (rx_sh),
        .ridx  (ptr_q),
        .rword (rword),
        .flat  (regs_o)
    );

    assign byte_done = evt.scl_fall && (cnt == FULL);
    assign we_hi     = (state == ST_WDAT) && byte_done && wr_hi_q;
    assign we_lo     = (state == ST_WDAT) && byte_done && !wr_hi_q;
    assign next_tx   = pick_byte(rword, !rd_hi_q);
    assign sda_oe    = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            oe_q    <= 1'b0;
            ptr_q   <= '0;
            wr_hi_q <= 1'b1;
            rd_hi_q <= 1'b1;
            nack_q  <= 1'b0;
        end else if (evt.start) begin
            state <= ST_ADDR;
            cnt   <= '0;
            oe_q  <= 1'b0;
        end else if (evt.stop) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_PTR, ST_WDAT: begin
                    if (evt.scl_rise && cnt != FULL) begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], evt.sda};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (rx_sh[7:1] == DEV_ADDR) begin
                                state   <= ST_AACK;
                                oe_q    <= 1'b1;
                                nack_q  <= rx_sh[0];
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else if (state == ST_PTR) begin
                            ptr_q   <= rx_sh[PTR_W-1:0];
                            wr_hi_q <= 1'b1;
                            state   <= ST_PACK;
                            oe_q    <= 1'b1;
                        end else begin
                            wr_hi_q <= !wr_hi_q;
                            state   <= ST_WACK;
                            oe_q    <= 1'b1;
                        end
                    end
                end
                ST_AACK: begin
                    if (evt.scl_fall) begin
                        if (nack_q) begin
                            state   <= ST_TX;
                            rd_hi_q <= 1'b1;
                            tx_sh   <= pick_byte(rword, 1'b1);
                            oe_q    <= ~rword[WORD_W-1];
                            nack_q  <= 1'b0;
                        end else begin
                            state <= ST_PTR;
                            oe_q  <= 1'b0;
                        end
                    end
                end
                ST_PACK, ST_WACK: begin
                    if (evt.scl_fall) begin
                        state <= ST_WDAT;
                        oe_q  <= 1'b0;
                    end
                end
                ST_TX: begin
                    if (evt.scl_rise && cnt != FULL) begin
                        cnt <= cnt + 1'b1;
                    end else if (evt.scl_fall) begin
                        if (cnt == FULL) begin
                            state <= ST_RACK;
                            oe_q  <= 1'b0;
                            cnt   <= '0;
                        end else begin
                            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                            oe_q  <= ~tx_sh[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (evt.scl_rise) begin
                        nack_q <= evt.sda;
                    end else if (evt.scl_fall) begin
                        if (nack_q) begin
                            state <= ST_SKIP;
                        end else begin
                            state   <= ST_TX;
                            rd_hi_q <= !rd_hi_q;
                            tx_sh   <= next_tx;
                            oe_q    <= ~next_tx[BYTE_W-1];
                        end
                        nack_q <= 1'b0;
                    end
                end
                ST_IDLE, ST_SKIP: begin
                    oe_q <= 1'b0;
                end
                default: begin
                    state <= ST_IDLE;
                    oe_q  <= 1'b0;
                end
            endcase
        end
    end

    a_r1_start_to_addr: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_ADDR && !sda_oe));
    a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE && !sda_oe));
    a_r4_skip_silent: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP && $past(state) == ST_SKIP) |-> !sda_oe);
    a_r12_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !evt.scl);
    a_r11_nack_ends: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RACK && evt.scl_fall && nack_q && !evt.start && !evt.stop) |=> state == ST_SKIP);
    a_r13_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe && regs_o == '0));

endmodule

// File: tb/sim_i2c_wreg_target.sv
module sim_i2c_wreg_target;

    localparam int CLK_P = 10;
    localparam int H     = 10;
    localparam logic [6:0] DADDR = 7'h2C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_c = 1'b1;
    logic        sda_oe;
    logic [63:0] regs_o;
    logic        sda_line;

    int checks = 0;
    int fails  = 0;
    logic [15:0] m_reg [4];
    int          m_ptr = 0;

    assign sda_line = sda_c & ~sda_oe;

    always #(CLK_P/2) clk = ~clk;

    i2c_wreg_target #(.DEV_ADDR(DADDR)) u0 (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .regs_o (regs_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] put_byte(input logic [15:0] w, input logic hi, input logic [7:0] b);
        return hi ? {b, w[7:0]} : {w[15:8], b};
    endfunction

    task automatic start_c();
        tick(H/2); sda_c = 1'b1; tick(H/2); scl = 1'b1; tick(H); sda_c = 1'b0; tick(H); scl = 1'b0;
    endtask

    task automatic stop_c();
        tick(H/2); sda_c = 1'b0; tick(H/2); scl = 1'b1; tick(H); sda_c = 1'b1; tick(H);
    endtask

    task automatic wbit(input logic b);
        tick(H/2); sda_c = b; tick(H - H/2); scl = 1'b1; tick(H); scl = 1'b0;
    endtask

    task automatic rbit(output logic b);
        logic a;
        tick(H/2); sda_c = 1'b1; tick(H - H/2); scl = 1'b1;
        tick(3); a = sda_line; tick(H-4); b = sda_line; tick(1); scl = 1'b0;
        chk("R12 stable in high", 32'(b), 32'(a));
    endtask

    task automatic send(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic recv(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(~give_ack);
    endtask

    task automatic check_regs(input string req);
        tick(4);
        for (int i = 0; i < 4; i++) chk(req, 32'(regs_o[i*16 +: 16]), 32'(m_reg[i]));
    endtask

    task automatic do_write(input int p, input int nb, input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input logic [7:0] d3, input logic rep);
        logic ack;
        logic hi;
        logic [7:0] d [4];
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
        start_c();
        send({DADDR, 1'b0}, ack); chk("R3 addr ack", 32'(ack), 1);
        send(8'(p), ack);         chk("R5 ptr ack", 32'(ack), 1);
        m_ptr = p & 3;
        hi = 1'b1;
        for (int k = 0; k < nb; k++) begin
            send(d[k], ack); chk("R6 data ack", 32'(ack), 1);
            m_reg[m_ptr] = put_byte(m_reg[m_ptr], hi, d[k]);
            hi = ~hi;
        end
        if (!rep) stop_c();
    endtask

    task automatic do_read(input int nb, input string req);
        logic ack;
        logic hi;
        logic [7:0] v;
        start_c();
        send({DADDR, 1'b1}, ack); chk("R3 read addr ack", 32'(ack), 1);
        hi = 1'b1;
        for (int k = 0; k < nb; k++) begin
            recv(k != nb-1, v);
            chk(req, 32'(v), 32'(hi ? m_reg[m_ptr][15:8] : m_reg[m_ptr][7:0]));
            hi = ~hi;
        end
        stop_c();
        chk("R2 released after stop", 32'(sda_oe), 0);
    endtask

    initial begin
        #(CLK_P * 190000);
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic ack;
        logic b;
        logic [7:0] v;
        void'($urandom(32'h5EED1));
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        tick(5);
        rst = 1'b0;
        tick(5);
        chk("R13 sda released", 32'(sda_oe), 0);
        check_regs("R13 regs zero");

        // R5/R6 full word write, R9 read with stored pointer
        do_write(2, 2, 8'hA5, 8'h5A, 8'h00, 8'h00, 1'b0);
        check_regs("R6 two bytes");
        do_read(2, "R9 read data");
        // R10 wrap on long read
        do_read(5, "R10 read wrap");

        // R7 one byte then repeated START (R1) into read
        do_write(1, 2, 8'h12, 8'h34, 8'h00, 8'h00, 1'b0);
        do_write(1, 1, 8'hC3, 8'h00, 8'h00, 8'h00, 1'b1);
        check_regs("R7 high only");
        do_read(2, "R1 repeated start read");

        // R8 four bytes alternate
        do_write(3, 4, 8'h11, 8'h22, 8'h33, 8'h44, 1'b0);
        check_regs("R8 wrap write");

        // R4 mismatched address
        start_c();
        send({DADDR ^ 7'h01, 1'b0}, ack); chk("R4 no ack", 32'(ack), 0);
        send(8'h00, ack); chk("R4 ptr ignored", 32'(ack), 0);
        send(8'hFF, ack); chk("R4 data ignored", 32'(ack), 0);
        stop_c();
        check_regs("R4 regs unchanged");

        // R11 nack then extra clocks
        start_c();
        send({DADDR, 1'b1}, ack); chk("R11 addr ack", 32'(ack), 1);
        recv(1'b0, v); chk("R11 byte", 32'(v), 32'(m_reg[m_ptr][15:8]));
        for (int i = 0; i < 9; i++) begin
            rbit(b); chk("R11 released", 32'(b), 1);
        end
        stop_c();

        // R2 stop mid pointer then normal write
        start_c();
        send({DADDR, 1'b0}, ack);
        wbit(1'b0); wbit(1'b1);
        stop_c();
        chk("R2 idle release", 32'(sda_oe), 0);
        do_write(0, 2, 8'hBE, 8'hEF, 8'h00, 8'h00, 1'b0);
        check_regs("R2 recover after stop");

        // random mix
        for (int t = 0; t < 30; t++) begin
            if ($urandom_range(1, 0) == 1) begin
                do_write(int'($urandom_range(255, 0)), int'($urandom_range(4, 1)),
                         8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'b0);
                check_regs("R6 random write");
            end else begin
                do_read(int'($urandom_range(4, 1)), "R9 random read");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule